// File: doc/BRIEF.md
# SD Card SPI-Mode Command Engine

This block sends single commands to an SD card that runs in SPI mode and brings back the card's reply. A host presents a 6-bit command index, a 32-bit argument and an application-command flag. The engine then selects the card, waits until the card reports ready, and sends the six-byte frame with the correct fixed check byte. It polls for the one-byte status reply, retrying the whole command when the card stays silent, and for application commands it sends the application-prefix command first. Depending on the command, it then collects a four-byte extended reply or waits out a busy period.

All traffic goes through a byte-wide transfer port. The engine raises a request with a byte to send. An external SPI shifter answers with a one-cycle acknowledge that carries the received byte. The engine drives chip select itself. It leaves the card selected after a successful read, write or card-data command, so that a data-phase engine can take over the bus. Every other outcome deselects the card. At the end of each command the engine reports the status byte, the extended word and a classified error code.

Top module: `sdc_cmd_engine`

## Requirements
- R1: A command frame is six bytes: `0x40 | index`, then the argument from its most significant byte down to its least significant byte, then a check byte.
- R2: The check byte is 0x95 for index 0, 0x87 for index 8 and 0xFF for every other index, including the prefix command 55.
- R3: Each command first sends one 0xFF with chip select unchanged and then drives chip select low. For any index other than 12 it then sends 0xFF bytes until one returns 0xFF or until WAIT_LIMIT bytes have been sent, and continues in either case.
- R4: After a frame the engine sends up to POLL_LIMIT (16) fill bytes of 0xFF. The first returned byte with bit 7 clear becomes the status byte; if no such byte arrives, the last returned byte is used. For index 12, one extra byte that directly follows the frame is discarded before polling starts.
- R5: If the status byte is 0xFF, the frame is sent again, up to MAX_TRIES (3) attempts in total. When the application flag is set, every attempt is preceded by a command-55 frame with argument 0, its reply poll (reply ignored) and a ready wait. If the last attempt also yields 0xFF, the error is 1 (no response).
- R6: The error code follows this priority: status bit 3 gives 2 (CRC), else bit 2 gives 3 (unsupported), else bit 1 or bit 4 gives 4 (erase), else bit 5 or bit 6 gives 5 (parameter), else 0 (none).
- R7: For indices 8 and 58, when the error is not 2 or 3, four more bytes are read, first byte most significant, into `ext_o`. In every other case `ext_o` is 0.
- R8: For indices 12 and 38, when the error is not 2 or 3, the engine sends 0xFF bytes until one returns 0xFF or until WAIT_LIMIT bytes have been sent.
- R9: Deselect drives chip select high and then sends one 0xFF. It is skipped, leaving chip select low, only when the error is 0 and the index is 9, 17, 18, 24 or 25, or the index is 22 with the application flag set.
- R10: A command is accepted when `cmd_valid_i` and `cmd_ready_o` are both high. `cmd_ready_o` stays low until `cmd_done_o`, a one-cycle pulse in which the results are valid. Each transfer request holds its byte steady until it is acknowledged.
- R11: After reset, chip select is high, no transfer is requested, `cmd_ready_o` is high and `cmd_done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command request |
| cmd_idx_i | input | 6 | Command index |
| cmd_arg_i | input | 32 | Command argument |
| cmd_app_i | input | 1 | Send the application prefix (index 55) before each attempt |
| cmd_ready_o | output | 1 | Engine idle, command can be accepted |
| cmd_done_o | output | 1 | One-cycle completion pulse |
| r1_o | output | 8 | Status byte of the command |
| ext_o | output | 32 | Extended four-byte reply |
| err_o | output | 3 | Error code (0 none, 1 no response, 2 CRC, 3 unsupported, 4 erase, 5 parameter) |
| cs_n_o | output | 1 | Card chip select, active low |
| xfer_req_o | output | 1 | Byte transfer request |
| xfer_tx_o | output | 8 | Byte to send |
| xfer_ack_i | input | 1 | Transfer done, one cycle |
| xfer_rx_i | input | 8 | Byte received, valid with acknowledge |

## Verification
Two decisions can fall on the same acknowledged byte. The first is the poll-limit cut-off and the retry decision: on the final attempt, the 16th poll byte must settle both whether a reply came and whether to retry. The second is the WAIT_LIMIT cut-off and the ready byte in the ready and busy waits. The bench provokes these by placing the reply exactly on the 16th poll byte after two silent attempts, and by holding the card not-ready past WAIT_LIMIT. It judges them by comparing the full logged byte stream and the chip-select level of each transfer against a script built from the requirements.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam logic [7:0] FILL_BYTE = 8'hFF;
  localparam logic [5:0] IDX_PREFIX = 6'd55;

  typedef enum logic [2:0] {
    ERR_NONE    = 3'd0,
    ERR_NO_RESP = 3'd1,
    ERR_CRC     = 3'd2,
    ERR_UNSUPP  = 3'd3,
    ERR_ERASE   = 3'd4,
    ERR_PARAM   = 3'd5
  } sdc_err_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SEL, ST_RDY, ST_FRAME, ST_STUFF, ST_POLL,
    ST_TAIL, ST_BUSY, ST_FIN, ST_DESEL, ST_DBYTE, ST_DONE
  } sdc_state_e;

  typedef struct packed {
    logic skip_ready;
    logic stuff;
    logic tail4;
    logic busy_tail;
    logic keep_sel;
  } sdc_attr_t;
endpackage

// File: rtl/sdc_frame_byte.sv
module sdc_frame_byte
  import sdc_pkg::*;
(
  input  logic [5:0]  idx_i,
  input  logic [31:0] arg_i,
  input  logic [2:0]  pos_i,
  output logic [7:0]  byte_o
);
  logic [7:0] chk_byte;

  always_comb begin
    case (idx_i)
      6'd0:    chk_byte = 8'h95;
      6'd8:    chk_byte = 8'h87;
      default: chk_byte = FILL_BYTE;
    endcase
  end

  always_comb begin
    case (pos_i)
      3'd0:    byte_o = {2'b01, idx_i};
      3'd1:    byte_o = arg_i[31:24];
      3'd2:    byte_o = arg_i[23:16];
      3'd3:    byte_o = arg_i[15:8];
      3'd4:    byte_o = arg_i[7:0];
      3'd5:    byte_o = chk_byte;
      default: byte_o = FILL_BYTE;
    endcase
  end
endmodule

// File: rtl/sdc_cmd_class.sv
module sdc_cmd_class
  import sdc_pkg::*;
(
  input  logic [5:0] idx_i,
  input  logic       app_i,
  output sdc_attr_t  attr_o
);
  always_comb begin
    attr_o            = '0;
    attr_o.skip_ready = (idx_i == 6'd12);
    attr_o.stuff      = (idx_i == 6'd12);
    attr_o.tail4      = (idx_i == 6'd8) || (idx_i == 6'd58);
    attr_o.busy_tail  = (idx_i == 6'd12) || (idx_i == 6'd38);
    case (idx_i)
      6'd9, 6'd17, 6'd18, 6'd24, 6'd25: attr_o.keep_sel = 1'b1;
      6'd22:                            attr_o.keep_sel = app_i;
      default:                          attr_o.keep_sel = 1'b0;
    endcase
  end
endmodule

// File: rtl/sdc_r1_classify.sv
module sdc_r1_classify
  import sdc_pkg::*;
(
  input  logic [6:1] flags_i,
  output sdc_err_e   err_o
);
  always_comb begin
    if (flags_i[3])                     err_o = ERR_CRC;
    else if (flags_i[2])                err_o = ERR_UNSUPP;
    else if (flags_i[1] || flags_i[4])  err_o = ERR_ERASE;
    else if (flags_i[5] || flags_i[6])  err_o = ERR_PARAM;
    else                                err_o = ERR_NONE;
  end
endmodule

// File: rtl/sdc_cmd_engine.sv
module sdc_cmd_engine
  import sdc_pkg::*;
#(
  parameter int WAIT_LIMIT = 4096,
  parameter int POLL_LIMIT = 16,
  parameter int MAX_TRIES  = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_valid_i,
  input  logic [5:0]  cmd_idx_i,
  input  logic [31:0] cmd_arg_i,
  input  logic        cmd_app_i,
  output logic        cmd_ready_o,
  output logic        cmd_done_o,
  output logic [7:0]  r1_o,
  output logic [31:0] ext_o,
  output logic [2:0]  err_o,
  output logic        cs_n_o,
  output logic        xfer_req_o,
  output logic [7:0]  xfer_tx_o,
  input  logic        xfer_ack_i,
  input  logic [7:0]  xfer_rx_i
);
  localparam int WW = $clog2(WAIT_LIMIT + 1);
  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam int TW = $clog2(MAX_TRIES + 1);
  localparam logic [WW-1:0] WAIT_LAST = WW'(WAIT_LIMIT - 1);
  localparam logic [PW-1:0] POLL_LAST = PW'(POLL_LIMIT - 1);
  localparam logic [TW-1:0] TRY_LAST  = TW'(MAX_TRIES - 1);

  sdc_state_e   state_q;
  logic [5:0]   idx_q;
  logic [31:0]  arg_q;
  logic         app_q, in_app_q, rdy_ret_q, cs_n_q;
  logic [2:0]   byte_cnt_q;
  logic [PW-1:0] poll_cnt_q;
  logic [WW-1:0] wait_cnt_q;
  logic [TW-1:0] tries_q;
  logic [7:0]   r1_q;
  logic [31:0]  ext_q;
  sdc_err_e     err_q;

  logic [5:0]   fr_idx;
  logic [31:0]  fr_arg;
  logic [7:0]   fr_byte;
  sdc_attr_t    attr;
  sdc_err_e     dec_err;
  logic         step;
  logic         rx_fill;

  assign fr_idx  = in_app_q ? IDX_PREFIX : idx_q;
  assign fr_arg  = in_app_q ? 32'd0 : arg_q;
  assign rx_fill = (xfer_rx_i == FILL_BYTE);

  sdc_frame_byte u_frame (
    .idx_i (fr_idx),
    .arg_i (fr_arg),
    .pos_i (byte_cnt_q),
    .byte_o(fr_byte)
  );

  sdc_cmd_class u_class (
    .idx_i (idx_q),
    .app_i (app_q),
    .attr_o(attr)
  );

  sdc_r1_classify u_classify (
    .flags_i(xfer_rx_i[6:1]),
    .err_o  (dec_err)
  );

  always_comb begin
    case (state_q)
      ST_SEL, ST_RDY, ST_FRAME, ST_STUFF, ST_POLL,
      ST_TAIL, ST_BUSY, ST_DBYTE: xfer_req_o = 1'b1;
      default:                    xfer_req_o = 1'b0;
    endcase
  end

  assign xfer_tx_o   = (state_q == ST_FRAME) ? fr_byte : FILL_BYTE;
  assign step        = xfer_req_o && xfer_ack_i;
  assign cmd_ready_o = (state_q == ST_IDLE);
  assign cmd_done_o  = (state_q == ST_DONE);
  assign r1_o        = r1_q;
  assign ext_o       = ext_q;
  assign err_o       = err_q;
  assign cs_n_o      = cs_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      arg_q      <= '0;
      app_q      <= 1'b0;
      in_app_q   <= 1'b0;
      rdy_ret_q  <= 1'b0;
      cs_n_q     <= 1'b1;
      byte_cnt_q <= '0;
      poll_cnt_q <= '0;
      wait_cnt_q <= '0;
      tries_q    <= '0;
      r1_q       <= FILL_BYTE;
      ext_q      <= '0;
      err_q      <= ERR_NONE;
    end else begin
      case (state_q)
        ST_IDLE: if (cmd_valid_i) begin
          idx_q   <= cmd_idx_i;
          arg_q   <= cmd_arg_i;
          app_q   <= cmd_app_i;
          ext_q   <= '0;
          err_q   <= ERR_NONE;
          tries_q <= '0;
          state_q <= ST_SEL;
        end
        ST_SEL: if (step) begin
          cs_n_q <= 1'b0;
          if (attr.skip_ready) begin
            in_app_q   <= app_q;
            byte_cnt_q <= '0;
            state_q    <= ST_FRAME;
          end else begin
            rdy_ret_q  <= 1'b0;
            wait_cnt_q <= '0;
            state_q    <= ST_RDY;
          end
        end
        ST_RDY: if (step) begin
          if (rx_fill || wait_cnt_q == WAIT_LAST) begin
            // first wait opens an attempt, wait after the prefix leads to the command
            in_app_q   <= rdy_ret_q ? 1'b0 : app_q;
            byte_cnt_q <= '0;
            state_q    <= ST_FRAME;
          end else begin
            wait_cnt_q <= wait_cnt_q + 1'b1;
          end
        end
        ST_FRAME: if (step) begin
          if (byte_cnt_q == 3'd5) begin
            poll_cnt_q <= '0;
            state_q    <= (!in_app_q && attr.stuff) ? ST_STUFF : ST_POLL;
          end else begin
            byte_cnt_q <= byte_cnt_q + 3'd1;
          end
        end
        ST_STUFF: if (step) begin
          poll_cnt_q <= '0;
          state_q    <= ST_POLL;
        end
        ST_POLL: if (step) begin
          if (!xfer_rx_i[7] || poll_cnt_q == POLL_LAST) begin
            if (in_app_q) begin
              rdy_ret_q  <= 1'b1;
              wait_cnt_q <= '0;
              state_q    <= ST_RDY;
            end else begin
              r1_q <= xfer_rx_i;
              if (rx_fill) begin
                if (tries_q == TRY_LAST) begin
                  err_q   <= ERR_NO_RESP;
                  state_q <= ST_DESEL;
                end else begin
                  tries_q    <= tries_q + 1'b1;
                  in_app_q   <= app_q;
                  byte_cnt_q <= '0;
                  state_q    <= ST_FRAME;
                end
              end else begin
                err_q <= dec_err;
                if (dec_err == ERR_CRC || dec_err == ERR_UNSUPP) begin
                  state_q <= ST_DESEL;
                end else if (attr.tail4) begin
                  byte_cnt_q <= '0;
                  state_q    <= ST_TAIL;
                end else if (attr.busy_tail) begin
                  wait_cnt_q <= '0;
                  state_q    <= ST_BUSY;
                end else begin
                  state_q <= ST_FIN;
                end
              end
            end
          end else begin
            poll_cnt_q <= poll_cnt_q + 1'b1;
          end
        end
        ST_TAIL: if (step) begin
          ext_q <= {ext_q[23:0], xfer_rx_i};
          if (byte_cnt_q == 3'd3) state_q <= ST_FIN;
          else byte_cnt_q <= byte_cnt_q + 3'd1;
        end
        ST_BUSY: if (step) begin
          if (rx_fill || wait_cnt_q == WAIT_LAST) state_q <= ST_FIN;
          else wait_cnt_q <= wait_cnt_q + 1'b1;
        end
        ST_FIN: begin
          if (err_q == ERR_NONE && attr.keep_sel) state_q <= ST_DONE;
          else state_q <= ST_DESEL;
        end
        ST_DESEL: begin
          cs_n_q  <= 1'b1;
          state_q <= ST_DBYTE;
        end
        ST_DBYTE: if (step) state_q <= ST_DONE;
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdc_cmd_engine_chk.sv
module sdc_cmd_engine_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_ready_o,
  input logic       cmd_done_o,
  input logic [7:0] r1_o,
  input logic [2:0] err_o,
  input logic       cs_n_o,
  input logic       xfer_req_o,
  input logic [7:0] xfer_tx_o,
  input logic       xfer_ack_i
);
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_done_o |=> !cmd_done_o);

  // R10
  busy_not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o |-> !cmd_ready_o);

  // R10
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_req_o && !xfer_ack_i) |=> (xfer_req_o && $stable(xfer_tx_o)));

  // R3
  sel_after_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_n_o) |-> ($past(xfer_ack_i) && $past(xfer_tx_o) == 8'hFF));

  // R9
  desel_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_n_o) |-> (xfer_req_o && xfer_tx_o == 8'hFF));

  // R9
  keep_only_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_done_o && !cs_n_o) |-> (err_o == 3'd0));

  // R5
  no_resp_r1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_done_o && err_o == 3'd1) |-> (r1_o == 8'hFF));

  // R6
  crc_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_done_o && r1_o != 8'hFF && r1_o[3]) |-> (err_o == 3'd2));
endmodule

bind sdc_cmd_engine sdc_cmd_engine_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_ready_o(cmd_ready_o),
  .cmd_done_o (cmd_done_o),
  .r1_o       (r1_o),
  .err_o      (err_o),
  .cs_n_o     (cs_n_o),
  .xfer_req_o (xfer_req_o),
  .xfer_tx_o  (xfer_tx_o),
  .xfer_ack_i (xfer_ack_i)
);

// File: tb/sim_sdc_cmd_engine.sv
`timescale 1ns/1ps
module sim_sdc_cmd_engine;
  localparam int WL = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [5:0]  cmd_idx = '0;
  logic [31:0] cmd_arg = '0;
  logic        cmd_app = 1'b0;
  logic        cmd_ready, cmd_done, cs_n, xfer_req;
  logic [7:0]  r1, xfer_tx;
  logic [31:0] ext;
  logic [2:0]  err;
  logic        xfer_ack = 1'b0;
  logic [7:0]  xfer_rx = 8'hFF;

  always #2.5 clk = ~clk;

  sdc_cmd_engine #(.WAIT_LIMIT(WL)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_idx_i(cmd_idx), .cmd_arg_i(cmd_arg), .cmd_app_i(cmd_app),
    .cmd_ready_o(cmd_ready), .cmd_done_o(cmd_done),
    .r1_o(r1), .ext_o(ext), .err_o(err), .cs_n_o(cs_n),
    .xfer_req_o(xfer_req), .xfer_tx_o(xfer_tx), .xfer_ack_i(xfer_ack), .xfer_rx_i(xfer_rx)
  );

  logic [7:0] rx_q [256];
  logic [7:0] exp_tx [256];
  logic [7:0] got_tx [256];
  logic       exp_cs [256];
  logic       got_cs [256];
  int n_exp, k_got;
  int checks = 0, failures = 0;
  bit cs_cur = 1'b1;
  bit finished = 1'b0;

  // card model: answers every request one negedge later with the scripted byte
  initial begin
    forever begin
      @(negedge clk);
      if (xfer_req && !xfer_ack) begin
        if (k_got < 256) begin
          got_tx[k_got] = xfer_tx;
          got_cs[k_got] = cs_n;
          xfer_rx = rx_q[k_got];
        end else begin
          xfer_rx = 8'hFF;
        end
        k_got++;
        xfer_ack = 1'b1;
      end else begin
        xfer_ack = 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic push(input logic [7:0] tx, input logic cs, input logic [7:0] rx);
    exp_tx[n_exp] = tx;
    exp_cs[n_exp] = cs;
    rx_q[n_exp]   = rx;
    n_exp++;
  endtask

  task automatic push_frame(input logic [5:0] idx, input logic [31:0] arg);
    logic [7:0] c;
    c = (idx == 6'd0) ? 8'h95 : (idx == 6'd8) ? 8'h87 : 8'hFF;
    push({2'b01, idx}, 1'b0, 8'hFF);
    for (int b = 3; b >= 0; b--) push(arg[8*b +: 8], 1'b0, 8'hFF);
    push(c, 1'b0, 8'hFF);
  endtask

  function automatic logic [2:0] exp_err(input logic [7:0] s);
    if (s[3]) return 3'd2;
    if (s[2]) return 3'd3;
    if (s[1] || s[4]) return 3'd4;
    if (s[5] || s[6]) return 3'd5;
    return 3'd0;
  endfunction

  task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg, input bit app,
                         input int nr, input int fails_n, input int pdly,
                         input logic [7:0] s, input logic [31:0] tailv, input int busyn,
                         input string tag);
    logic [7:0]  e_r1;
    logic [2:0]  e_err;
    logic [31:0] e_ext;
    bit keep, seen;
    int tries, bad;
    for (int i = 0; i < 256; i++) rx_q[i] = 8'hFF;
    n_exp = 0;
    k_got = 0;
    push(8'hFF, cs_cur, 8'hFF);
    cs_cur = 1'b0;
    if (idx != 6'd12) begin
      if (nr >= WL) for (int i = 0; i < WL; i++) push(8'hFF, 1'b0, 8'h00);
      else begin
        for (int i = 0; i < nr; i++) push(8'hFF, 1'b0, 8'h00);
        push(8'hFF, 1'b0, 8'hFF);
      end
    end
    tries = (fails_n >= 3) ? 3 : fails_n + 1;
    for (int a = 0; a < tries; a++) begin
      if (app) begin
        push_frame(6'd55, 32'd0);
        push(8'hFF, 1'b0, 8'h01);
        push(8'hFF, 1'b0, 8'hFF);
      end
      push_frame(idx, arg);
      if (idx == 6'd12) push(8'hFF, 1'b0, 8'h00);
      if (a < fails_n) for (int i = 0; i < 16; i++) push(8'hFF, 1'b0, 8'hFF);
      else begin
        for (int i = 0; i < pdly; i++) push(8'hFF, 1'b0, 8'hFF);
        push(8'hFF, 1'b0, s);
      end
    end
    e_ext = 32'd0;
    if (fails_n >= 3) begin
      e_r1 = 8'hFF;
      e_err = 3'd1;
    end else begin
      e_r1 = s;
      e_err = exp_err(s);
      if (e_err != 3'd2 && e_err != 3'd3) begin
        if (idx == 6'd8 || idx == 6'd58) begin
          for (int b = 3; b >= 0; b--) push(8'hFF, 1'b0, tailv[8*b +: 8]);
          e_ext = tailv;
        end else if (idx == 6'd12 || idx == 6'd38) begin
          if (busyn >= WL) for (int i = 0; i < WL; i++) push(8'hFF, 1'b0, 8'h00);
          else begin
            for (int i = 0; i < busyn; i++) push(8'hFF, 1'b0, 8'h00);
            push(8'hFF, 1'b0, 8'hFF);
          end
        end
      end
    end
    keep = (e_err == 3'd0) &&
           (idx == 6'd9 || idx == 6'd17 || idx == 6'd18 || idx == 6'd24 || idx == 6'd25 ||
            (idx == 6'd22 && app));
    if (!keep) begin
      push(8'hFF, 1'b1, 8'hFF);
      cs_cur = 1'b1;
    end

    @(negedge clk);
    cmd_valid = 1'b1; cmd_idx = idx; cmd_arg = arg; cmd_app = app;
    @(negedge clk);
    cmd_valid = 1'b0;
    seen = 1'b0;
    for (int c = 0; c < 3000; c++) begin
      if (cmd_done) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    chk(seen, {tag, " R10 done pulse"}, 32'(seen), 32'd1);
    chk(k_got == n_exp, {tag, " transfer count"}, 32'(k_got), 32'(n_exp));
    bad = -1;
    for (int i = 0; i < n_exp; i++)
      if (got_tx[i] !== exp_tx[i] || got_cs[i] !== exp_cs[i]) begin bad = i; break; end
    if (bad >= 0)
      chk(1'b0, $sformatf("%s byte %0d tx/cs", tag, bad),
          {23'd0, got_cs[bad], got_tx[bad]}, {23'd0, exp_cs[bad], exp_tx[bad]});
    else chk(1'b1, tag, 0, 0);
    chk(r1 === e_r1, {tag, " R4 status byte"}, {24'd0, r1}, {24'd0, e_r1});
    chk(err === e_err, {tag, " R6 error"}, {29'd0, err}, {29'd0, e_err});
    chk(ext === e_ext, {tag, " R7 ext"}, ext, e_ext);
    chk(cs_n === cs_cur, {tag, " R9 chip select"}, {31'd0, cs_n}, {31'd0, cs_cur});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int sel, fn;
    logic [5:0] ri;
    void'($urandom(32'd7391));
    for (int i = 0; i < 256; i++) rx_q[i] = 8'hFF;
    n_exp = 0; k_got = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(cs_n === 1'b1 && xfer_req === 1'b0 && cmd_ready === 1'b1 && cmd_done === 1'b0,
        "R11 reset outputs", {28'd0, cs_n, xfer_req, cmd_ready, cmd_done}, 32'h0000_000A);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_cmd(6'd0,  32'd0,        0, 2, 0, 1,  8'h01, 0, 0, "R1 R2 R3 reset cmd");
    run_cmd(6'd8,  32'h0000_01AA, 0, 0, 0, 0, 8'h01, 32'h0000_01AA, 0, "R2 R7 cond cmd");
    run_cmd(6'd17, 32'h0000_1000, 0, 1, 0, 3, 8'h00, 0, 0, "R9 read keep");
    run_cmd(6'd12, 32'd0,        0, 0, 0, 2,  8'h00, 0, 3, "R4 R8 stop cmd");
    run_cmd(6'd41, 32'h4000_0000, 1, 0, 0, 0, 8'h00, 0, 0, "R5 app cmd");
    run_cmd(6'd58, 32'd0,        0, 0, 3, 0,  8'h00, 0, 0, "R5 no response");
    run_cmd(6'd41, 32'h4000_0000, 1, 3, 2, 15, 8'h01, 0, 0, "R4 R5 late reply");
    run_cmd(6'd17, 32'h0000_0200, 0, 0, 0, 0, 8'h08, 0, 0, "R6 R9 crc");
    run_cmd(6'd16, 32'd512,      0, 0, 0, 0,  8'h7E, 0, 0, "R6 crc priority");
    run_cmd(6'd16, 32'd512,      0, 0, 0, 0,  8'h16, 0, 0, "R6 unsupported");
    run_cmd(6'd16, 32'd512,      0, 0, 0, 0,  8'h72, 0, 0, "R6 erase");
    run_cmd(6'd16, 32'd512,      0, 0, 0, 0,  8'h40, 0, 0, "R6 parameter");
    run_cmd(6'd58, 32'd0,        0, 0, 0, 0,  8'h20, 32'hC0FF_8000, 0, "R6 R7 param tail");
    run_cmd(6'd24, 32'h0000_0400, 0, WL + 3, 0, 0, 8'h00, 0, 0, "R3 ready timeout");
    run_cmd(6'd38, 32'd0,        0, 0, 0, 0,  8'h00, 0, WL + 5, "R8 busy timeout");
    run_cmd(6'd22, 32'd0,        1, 0, 0, 0,  8'h00, 0, 0, "R9 app keep");
    run_cmd(6'd9,  32'd0,        0, 0, 0, 0,  8'h20, 0, 0, "R9 param deselect");

    for (int t = 0; t < 40; t++) begin
      sel = int'($urandom % 12);
      case (sel)
        0: ri = 6'd0;   1: ri = 6'd8;   2: ri = 6'd9;   3: ri = 6'd12;
        4: ri = 6'd16;  5: ri = 6'd17;  6: ri = 6'd24;  7: ri = 6'd38;
        8: ri = 6'd41;  9: ri = 6'd55;  10: ri = 6'd58; default: ri = 6'd22;
      endcase
      fn = ($urandom % 5 == 0) ? int'($urandom % 4) : 0;
      run_cmd(ri, $urandom, 1'($urandom), int'($urandom % (WL + 2)), fn,
              int'($urandom % 16), ($urandom % 2 == 0) ? 8'h00 : 8'($urandom % 128),
              $urandom, int'($urandom % (WL + 2)), "R1 R5 R6 R8 random");
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule